// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side it watches the UART output line. It emits one short high pulse on the optical output for every zero bit, and that includes the start bit. A one bit, a stop bit or an idle line produces no pulse. On the receive side it takes the active-low optical input, drops short glitches, and rebuilds a UART-level stream. That stream idles high and goes low for about one bit period after each accepted pulse.

Bit boundaries always come from the UART's 16x oversampling tick. The pulse can be timed in two ways. In normal mode it lasts three oversampling ticks and starts at the beginning of the bit. In low-power mode it lasts exactly three periods of a slow tick, which a programmable 8-bit prescaler divides from the system clock. The receive glitch filter always runs on the prescaler tick, whichever mode is selected.

The link is half-duplex. While the transmit side is busy with a frame, the receive output is held at idle, so the block never hears its own echo.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset `ir_tx` is 0 and `uart_rxd` is 1, and both stay there while the inputs stay idle.
- R2: With `lp_mode`=0, each UART bit of value 0 on `uart_txd` gives exactly one `ir_tx` high pulse. The pulse starts on the clock after the `os_tick` that opens the bit and lasts exactly 3 `os_tick` periods. A bit of value 1 gives no pulse.
- R3: With `lp_mode`=1, each 0 bit gives exactly one `ir_tx` pulse that starts and ends on slow ticks and lasts exactly 3 slow-tick periods. The slow-tick period is `psc_val` clock cycles.
- R4: A `psc_val` of 0 divides by 1, so the slow tick fires every clock cycle.
- R5: A low pulse on `ir_rx_n` lasting at most one slow-tick period (W <= divisor clock cycles) never makes `uart_rxd` go low.
- R6: A low pulse on `ir_rx_n` lasting at least two slow-tick periods always makes `uart_rxd` go low once. The low lasts between 15 and 16 `os_tick` periods, counting in clock cycles from the cycle after detection.
- R7: The receive filter behaves the same way whatever the value of `lp_mode`.
- R8: While a frame is being sent, `uart_rxd` stays 1 and pulses on `ir_rx_n` are ignored. A frame counts as being sent from the first 0 sampled on `uart_txd` until 10 bit periods after the last 0 sampled, or while a pulse is pending or active. Reception resumes once that window has ended.
- R9: A frame of pulses at bit starts on `ir_rx_n`, one pulse per 0 bit, each lasting 3 `os_tick` periods, is rebuilt on `uart_rxd`. A sample taken mid-bit matches every bit, start bit and stop bit included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode | input | 1 | 1 selects low-power pulse timing from the slow tick |
| psc_val | input | 8 | Slow-tick divide ratio, where 0 means divide by 1 |
| os_tick | input | 1 | One-cycle strobe at 16 times the baud rate |
| uart_txd | input | 1 | Serial stream from the UART transmitter |
| ir_rx_n | input | 1 | Active-low input from the infrared receiver |
| ir_tx | output | 1 | Active-high drive to the infrared emitter |
| uart_rxd | output | 1 | Rebuilt serial stream to the UART receiver, idles high |

## Verification
The bench builds the block with its default parameters: 16 oversampling ticks per bit, a 3-tick pulse, a 10-bit busy window and a two-stage input synchronizer. It drives `os_tick` every 8 clocks, so one bit period is 128 cycles. This makes the 3-tick pulse, the 16-tick receive stretch and the full busy window short enough to measure to the exact cycle. It also lets prescaler values up to 30 fit a whole low-power pulse inside one bit. It sweeps prescaler values that include 0 and 1, so that both ends of the glitch window can be probed in a few cycles, one clock either side of one and two divisor periods.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

  typedef enum logic [1:0] {
    ENC_IDLE  = 2'd0,
    ENC_WAIT  = 2'd1,
    ENC_PULSE = 2'd2
  } enc_state_e;

  // Prescaler field to clock-cycle divisor; zero is treated as one.
  function automatic int unsigned slow_div(input int unsigned psc);
    return (psc == 0) ? 1 : psc;
  endfunction

  // Oversampling ticks the transmit side stays busy after its last zero.
  function automatic int unsigned hold_ticks(input int unsigned bits,
                                             input int unsigned os_per_bit);
    return bits * os_per_bit;
  endfunction

endpackage

// File: rtl/irda_sir_prescaler.sv
module irda_sir_prescaler
  import irda_sir_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_val,
  output logic             slow_tick
);

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W:0]   last_cnt;

  assign last_cnt  = (PSC_W+1)'(slow_div(32'(psc_val)) - 1);
  assign slow_tick = ({1'b0, cnt_q} >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (slow_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder
  import irda_sir_pkg::*;
#(
  parameter int OS_PER_BIT  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int HOLD_BITS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode,
  input  logic os_tick,
  input  logic slow_tick,
  input  logic uart_txd,
  output logic ir_tx,
  output logic bit_start,
  output logic tx_busy
);

  localparam int PH_W       = $clog2(OS_PER_BIT);
  localparam int PC_W       = $clog2(PULSE_TICKS + 1);
  localparam int HOLD_TICKS = hold_ticks(HOLD_BITS, OS_PER_BIT);
  localparam int HD_W       = $clog2(HOLD_TICKS + 1);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OS_PER_BIT - 1);
  localparam logic [PC_W-1:0] PC_LOAD   = PC_W'(PULSE_TICKS);
  localparam logic [HD_W-1:0] HOLD_LOAD = HD_W'(HOLD_TICKS);

  logic            txd_q;
  logic [PH_W-1:0] phase_q;
  logic            txd_changed;
  logic            start_req;
  logic            pulse_tick;

  enc_state_e      state_q, state_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [HD_W-1:0] hold_q;

  // Bit framing: restart the phase on any level change, else wrap every bit.
  assign txd_changed = (uart_txd != txd_q);
  assign bit_start   = os_tick && (txd_changed || (phase_q == PH_LAST));
  assign start_req   = bit_start && !uart_txd;
  assign pulse_tick  = lp_mode ? slow_tick : os_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b1;
      phase_q <= '0;
    end else if (os_tick) begin
      txd_q   <= uart_txd;
      phase_q <= (txd_changed || phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      ENC_IDLE: begin
        if (start_req) begin
          if (lp_mode) begin
            state_d = ENC_WAIT;
          end else begin
            state_d = ENC_PULSE;
            pcnt_d  = PC_LOAD;
          end
        end
      end
      ENC_WAIT: begin
        if (pulse_tick) begin
          state_d = ENC_PULSE;
          pcnt_d  = PC_LOAD;
        end
      end
      ENC_PULSE: begin
        if (pulse_tick) begin
          if (pcnt_q == PC_W'(1)) state_d = ENC_IDLE;
          else                    pcnt_d  = pcnt_q - 1'b1;
        end
      end
      default: state_d = ENC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENC_IDLE;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end

  // Busy window: reloaded on every zero seen, drains over the trailing ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (os_tick) begin
      if (!uart_txd)        hold_q <= HOLD_LOAD;
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
    end
  end

  assign ir_tx   = (state_q == ENC_PULSE);
  assign tx_busy = (hold_q != 0) || (state_q != ENC_IDLE);

endmodule

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder
  import irda_sir_pkg::*;
#(
  parameter int OS_PER_BIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic slow_tick,
  input  logic ir_rx_n,
  input  logic tx_busy,
  output logic uart_rxd,
  output logic pulse_det
);

  localparam int SW = $clog2(OS_PER_BIT + 1);
  localparam logic [SW-1:0] STRETCH = SW'(OS_PER_BIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   samp_q;
  logic                   armed_q;
  logic [SW-1:0]          stretch_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= ir_rx_n;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_rx_n};
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC_STAGES-1];

  // A pulse counts only when two successive slow-tick samples are both low.
  assign pulse_det = slow_tick && !rx_s && !samp_q && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b1;
      armed_q <= 1'b1;
    end else if (slow_tick) begin
      samp_q  <= rx_s;
      armed_q <= rx_s ? 1'b1 : (pulse_det ? 1'b0 : armed_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         stretch_q <= '0;
    else if (tx_busy)                   stretch_q <= '0;
    else if (pulse_det)                 stretch_q <= STRETCH;
    else if (os_tick && stretch_q != 0) stretch_q <= stretch_q - 1'b1;
  end

  assign uart_rxd = (stretch_q == 0) || tx_busy;

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
  import irda_sir_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int OS_PER_BIT  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int HOLD_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_mode,
  input  logic [PSC_W-1:0] psc_val,
  input  logic             os_tick,
  input  logic             uart_txd,
  input  logic             ir_rx_n,
  output logic             ir_tx,
  output logic             uart_rxd
);

  logic slow_tick;
  logic tx_busy;
  logic bit_start;
  logic pulse_det;

  irda_sir_prescaler #(.PSC_W(PSC_W)) presc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .psc_val   (psc_val),
    .slow_tick (slow_tick)
  );

  irda_sir_encoder #(
    .OS_PER_BIT  (OS_PER_BIT),
    .PULSE_TICKS (PULSE_TICKS),
    .HOLD_BITS   (HOLD_BITS)
  ) enc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_mode   (lp_mode),
    .os_tick   (os_tick),
    .slow_tick (slow_tick),
    .uart_txd  (uart_txd),
    .ir_tx     (ir_tx),
    .bit_start (bit_start),
    .tx_busy   (tx_busy)
  );

  irda_sir_decoder #(
    .OS_PER_BIT  (OS_PER_BIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .slow_tick (slow_tick),
    .ir_rx_n   (ir_rx_n),
    .tx_busy   (tx_busy),
    .uart_rxd  (uart_rxd),
    .pulse_det (pulse_det)
  );

endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk
  import irda_sir_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lp_mode,
  input logic [PSC_W-1:0] psc_val,
  input logic             os_tick,
  input logic             slow_tick,
  input logic             uart_txd,
  input logic             bit_start,
  input logic             ir_tx,
  input logic             uart_rxd,
  input logic             tx_busy,
  input logic             pulse_det
);

  int               gap;
  logic [PSC_W-1:0] psc_q;
  logic             dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= 0;
      psc_q <= '0;
      dirty <= 1'b1;
    end else begin
      psc_q <= psc_val;
      if (slow_tick)        gap <= 0;
      else if (gap < 65535) gap <= gap + 1;
      if (psc_val != psc_q) dirty <= 1'b1;
      else if (slow_tick)   dirty <= 1'b0;
    end
  end

  // R8
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> uart_rxd);

  // R2
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ir_tx) && !lp_mode) |-> $past(bit_start && !uart_txd));

  // R3
  tx_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(lp_mode ? slow_tick : os_tick));

  // R3
  tx_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ir_tx) |-> $past(lp_mode ? slow_tick : os_tick));

  // R6
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uart_rxd) |-> $past(pulse_det));

  // R4
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !dirty && psc_val == psc_q)
      |-> (gap == int'(slow_div(32'(psc_val))) - 1));

endmodule

bind irda_sir_codec irda_sir_codec_chk #(.PSC_W(PSC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lp_mode   (lp_mode),
  .psc_val   (psc_val),
  .os_tick   (os_tick),
  .slow_tick (slow_tick),
  .uart_txd  (uart_txd),
  .bit_start (bit_start),
  .ir_tx     (ir_tx),
  .uart_rxd  (uart_rxd),
  .tx_busy   (tx_busy),
  .pulse_det (pulse_det)
);

// File: tb/irda_sir_codec_tb.sv
module irda_sir_codec_tb_top;

  localparam int OS_DIV     = 8;
  localparam int OS_PER_BIT = 16;
  localparam int BIT_CYC    = OS_DIV * OS_PER_BIT;
  localparam int HOLD_BITS  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_mode = 1'b0;
  logic [7:0] psc_val = 8'd4;
  logic       os_tick = 1'b0;
  logic       uart_txd = 1'b1;
  logic       ir_rx_n = 1'b1;
  logic       ir_tx;
  logic       uart_rxd;

  int checks = 0;
  int fails  = 0;
  int os_cnt = 0;
  int exp_w  = 0;
  int tx_pulses = 0, tx_badw = 0, tx_run = 0, tx_lastw = 0;
  int rx_lows = 0, rx_run = 0, rx_lastlow = 0;
  bit finished = 0;

  irda_sir_codec dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_mode  (lp_mode),
    .psc_val  (psc_val),
    .os_tick  (os_tick),
    .uart_txd (uart_txd),
    .ir_rx_n  (ir_rx_n),
    .ir_tx    (ir_tx),
    .uart_rxd (uart_rxd)
  );

  always #10 clk = ~clk;

  function automatic int div_of(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int zeros_in(input logic [7:0] d);
    int z = 1;
    for (int i = 0; i < 8; i++) if (!d[i]) z++;
    return z;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      os_cnt  = (os_cnt == OS_DIV - 1) ? 0 : os_cnt + 1;
      os_tick = (os_cnt == 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (ir_tx) tx_run++;
      else if (tx_run > 0) begin
        tx_pulses++;
        tx_lastw = tx_run;
        if (tx_run != exp_w) tx_badw++;
        tx_run = 0;
      end
      if (!uart_rxd) rx_run++;
      else if (rx_run > 0) begin
        rx_lows++;
        rx_lastlow = rx_run;
        rx_run = 0;
      end
    end
  end

  task automatic wait_os(input int n);
    repeat (n) begin
      do @(posedge clk); while (!os_tick);
    end
  endtask

  task automatic send_frame(input logic [7:0] d);
    logic [9:0] bits = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      uart_txd = bits[i];
      wait_os(OS_PER_BIT);
    end
  endtask

  // R2 R3 R4: pulse count and exact width for one frame
  task automatic tx_case(input bit lp, input int psc, input logic [7:0] d, input string req);
    @(negedge clk);
    lp_mode = lp;
    psc_val = 8'(psc);
    exp_w = lp ? 3 * div_of(psc) : 3 * OS_DIV;
    tx_pulses = 0;
    tx_badw = 0;
    send_frame(d);
    wait_os(OS_PER_BIT * (HOLD_BITS + 2));
    check(tx_pulses == zeros_in(d), req, tx_pulses, zeros_in(d));
    check(tx_badw == 0, req, tx_lastw, exp_w);
  endtask

  task automatic rx_pulse(input int w);
    @(negedge clk);
    ir_rx_n = 1'b0;
    repeat (w) @(negedge clk);
    ir_rx_n = 1'b1;
  endtask

  // R5 R6 R7: glitch window and stretch length
  task automatic glitch(input bit lp, input int psc, input int w);
    int dv = div_of(psc);
    @(negedge clk);
    lp_mode = lp;
    psc_val = 8'(psc);
    repeat (2 * dv + 4) @(negedge clk);
    rx_lows = 0;
    rx_lastlow = 0;
    rx_pulse(w);
    repeat (BIT_CYC + 3 * dv + 40) @(negedge clk);
    if (w <= dv) begin
      check(rx_lows == 0, lp ? "R5 R7 lp" : "R5", rx_lows, 0);
    end else if (w >= 2 * dv) begin
      check(rx_lows == 1, lp ? "R6 R7 lp" : "R6", rx_lows, 1);
      check(rx_lastlow >= (OS_PER_BIT - 1) * OS_DIV + 1 && rx_lastlow <= BIT_CYC,
            "R6 stretch", rx_lastlow, BIT_CYC);
    end else begin
      check(rx_lows <= 1, "R5 R6 window", rx_lows, 1);
    end
  endtask

  // R9: rebuild a pulsed frame
  task automatic decode_frame(input bit lp, input int psc, input logic [7:0] d);
    logic [9:0] bits = {1'b1, d, 1'b0};
    logic [9:0] got;
    @(negedge clk);
    lp_mode = lp;
    psc_val = 8'(psc);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (!bits[i]) begin
        ir_rx_n = 1'b0;
        repeat (3 * OS_DIV) @(negedge clk);
        ir_rx_n = 1'b1;
        repeat (BIT_CYC / 2 - 3 * OS_DIV) @(negedge clk);
      end else begin
        repeat (BIT_CYC / 2) @(negedge clk);
      end
      got[i] = uart_rxd;
      repeat (BIT_CYC / 2) @(negedge clk);
    end
    check(got == bits, "R9", int'(got), int'(bits));
    repeat (2 * BIT_CYC) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    // R1
    check(ir_tx == 1'b0, "R1 ir_tx", int'(ir_tx), 0);
    check(uart_rxd == 1'b1, "R1 uart_rxd", int'(uart_rxd), 1);

    tx_case(1'b0, 4, 8'h00, "R2 all zero");
    tx_case(1'b0, 4, 8'hFF, "R2 all one");
    tx_case(1'b0, 4, 8'h5A, "R2 pattern");
    for (int k = 0; k < 3; k++) tx_case(1'b0, 4, 8'($urandom), "R2 random");

    tx_case(1'b1, 0, 8'h33, "R4 psc zero");
    tx_case(1'b1, 1, 8'hA5, "R3 psc one");
    tx_case(1'b1, 7, 8'h0F, "R3 psc seven");
    for (int k = 0; k < 3; k++)
      tx_case(1'b1, 2 + int'($urandom % 29), 8'($urandom), "R3 random");

    // R8: own-echo suppression during a frame, then release
    lp_mode = 1'b0;
    psc_val = 8'd4;
    rx_lows = 0;
    fork
      send_frame(8'h00);
      begin
        repeat (40) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          rx_pulse(3 * OS_DIV);
          repeat (BIT_CYC - 3 * OS_DIV - 1) @(negedge clk);
        end
      end
    join
    check(rx_lows == 0 && uart_rxd, "R8 masked", rx_lows, 0);
    wait_os(OS_PER_BIT * (HOLD_BITS + 2));
    rx_lows = 0;
    rx_pulse(3 * OS_DIV);
    repeat (BIT_CYC + 40) @(negedge clk);
    check(rx_lows == 1, "R8 release", rx_lows, 1);

    glitch(1'b0, 4, 4);
    glitch(1'b0, 4, 8);
    glitch(1'b1, 4, 4);
    glitch(1'b1, 4, 8);
    glitch(1'b0, 0, 1);
    glitch(1'b0, 0, 2);
    glitch(1'b1, 12, 12);
    glitch(1'b1, 12, 24);
    for (int k = 0; k < 20; k++) begin
      int p = 1 + int'($urandom % 12);
      glitch(1'($urandom), p, 1 + int'($urandom % (3 * p)));
    end

    decode_frame(1'b0, 4, 8'h00);
    decode_frame(1'b1, 8, 8'hC3);
    for (int k = 0; k < 4; k++)
      decode_frame(1'($urandom), 1 + int'($urandom % 8), 8'($urandom));

    check(ir_tx == 1'b0 && uart_rxd == 1'b1, "R1 idle end", int'(uart_rxd), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule